// File: doc/BRIEF.md
# Linked-List Transmit Descriptor Engine

This engine walks a chain of transmit descriptors kept in system memory and turns each one into a byte stream for a downstream framer. Each descriptor is four 32-bit little-endian words. The engine reads a descriptor, checks that the engine owns it, and fetches the packet buffer one word per memory beat. It emits the buffer one byte per cycle, pads short packets with zeros when asked, and writes the descriptor back so that ownership returns to software. It then follows the next pointer and carries on until it meets a descriptor that software still owns.

Software sets the list start address and raises the enable level, which loads the current-descriptor pointer. A poll pulse then starts the walk. Single-cycle event pulses report completed packets, a missing descriptor and bus errors to a separate interrupt block. That block returns its transmit summary level, and the engine copies it into each descriptor's status.

Top module: `txdesc_walker`

## Requirements
- R1: After reset the engine is idle. `mem_req`, `out_valid` and all event pulses are low, and `cur_desc` and `cur_buf` read zero.
- R2: A 0-to-1 change of `tx_en` loads `cur_desc` with `list_base`, low two bits cleared. No memory request follows until a poll pulse.
- R3: A poll pulse while `tx_en` is low has no effect. A poll while `tx_en` is high starts a walk that keeps processing descriptors until the engine halts.
- R4: Descriptor layout is word offset 0 flags, 4 buffer address, 8 status-and-length, 12 next-descriptor address. Flags bit 31 set means the engine owns the descriptor. If bit 31 is clear, the engine pulses `ev_unavail`, halts, writes nothing and leaves `cur_desc` on that descriptor.
- R5: The packet length is bits 15:0 of the status word. The bytes are streamed from the buffer address, which may have any byte alignment, in ascending address order. Byte k of a memory word is bits 8k+7:8k. `out_last` marks the final byte.
- R6: When flags bit 0 is set and the length is below `MIN_LEN`, zero bytes follow the buffer bytes up to `MIN_LEN` in total, and `out_last` sits on the last pad byte.
- R7: Write-back stores the flags word with bit 31 cleared. It then stores a status word that holds the length in bits 15:0, sets bit 16 on successful transmission and clears all other upper bits. `cur_desc` then moves to the next address with its low two bits cleared.
- R8: `ev_done` pulses once per successfully sent descriptor, and only when its flags bit 2 is set.
- R9: Status bit 17 holds `summary_irq` as sampled when the flags write-back completes. It is set only for a successful transmission.
- R10: An error on a buffer read pulses `ev_buserr` and stops the bytes of that packet. The descriptor is still written back without bits 16 and 17, and the walk continues with the next descriptor.
- R11: An error while reading a descriptor word pulses `ev_buserr` and halts without write-back, and `cur_desc` is left unchanged.
- R12: `cur_buf` shows the buffer address of the most recently fetched descriptor.
- R13: Clearing `tx_en` stops the engine after the memory beat in progress. No further bytes or requests follow, and the interrupted descriptor is not written back.
- R14: A memory request keeps its address, direction and write data stable until `mem_ack` or `mem_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable level |
| poll | input | 1 | Poll-demand pulse |
| list_base | input | ADDR_W | Address of the first descriptor |
| summary_irq | input | 1 | Transmit summary interrupt level from the interrupt block |
| mem_req | output | 1 | Memory request, held until ack or error |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Beat completed |
| mem_err | input | 1 | Beat failed |
| out_valid | output | 1 | Byte valid on `out_data` |
| out_data | output | 8 | Packet byte |
| out_last | output | 1 | Final byte of the packet |
| ev_done | output | 1 | Transmit-complete event pulse |
| ev_unavail | output | 1 | Descriptor-unavailable event pulse |
| ev_buserr | output | 1 | Bus-error event pulse |
| cur_desc | output | ADDR_W | Current descriptor address |
| cur_buf | output | ADDR_W | Current buffer address |

## Verification
A byte appears on the stream in the cycle after the edge that accepts its buffer word, and the remaining bytes of that word follow one per cycle. Event pulses are registered, so they appear one cycle after the deciding edge. `cur_desc` advances on the edge that completes the status write-back. The reference model in the bench predicts the byte and last-flag sequence. It compares that sequence with the stream at a fixed point 4 ns after every edge, so the exact cycle of each byte does not matter. Event counts, descriptor contents in memory and the two pointer outputs are compared once the engine has halted and the memory has gone quiet.

// File: rtl/txdesc_walker.sv
module txdesc_walker #(
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              poll,
  input  logic [ADDR_W-1:0] list_base,
  input  logic              summary_irq,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              out_last,
  output logic              ev_done,
  output logic              ev_unavail,
  output logic              ev_buserr,
  output logic [ADDR_W-1:0] cur_desc,
  output logic [ADDR_W-1:0] cur_buf
);

  localparam int OWN_B  = 31;
  localparam int PAD_B  = 0;
  localparam int IE_B   = 2;
  localparam int SENT_B = 16;
  localparam int INTR_B = 17;
  localparam logic [ADDR_W-1:0] WMASK = ~ADDR_W'(3);
  localparam logic [LEN_W-1:0]  MINL  = LEN_W'(MIN_LEN);

  typedef enum logic [3:0] {
    S_IDLE, S_DFLG, S_DBUF, S_DLEN, S_DNXT, S_FETCH, S_EMIT, S_PAD, S_WFLG, S_WLEN
  } st_t;

  st_t               st;
  logic [31:0]       flags_q, word_q;
  logic [ADDR_W-1:0] next_q, rd_ptr;
  logic [LEN_W-1:0]  len_q, cnt;
  logic              berr_q, intr_q, en_q;

  wire beat_end  = mem_ack | mem_err;
  wire abort     = !tx_en && (!mem_req || beat_end);
  wire pad_need  = flags_q[PAD_B] && (len_q < MINL);
  wire [LEN_W-1:0] total = pad_need ? MINL : len_q;
  wire buf_last  = (cnt == len_q - LEN_W'(1));
  wire pad_last  = (cnt == total - LEN_W'(1));

  assign mem_req   = (st == S_DFLG) || (st == S_DBUF) || (st == S_DLEN) || (st == S_DNXT) ||
                     (st == S_FETCH) || (st == S_WFLG) || (st == S_WLEN);
  assign mem_we    = (st == S_WFLG) || (st == S_WLEN);
  assign out_valid = tx_en && ((st == S_EMIT) || (st == S_PAD));
  assign out_data  = (st == S_EMIT) ? word_q[{rd_ptr[1:0], 3'b000} +: 8] : 8'h00;
  assign out_last  = out_valid && ((st == S_EMIT) ? (buf_last && !pad_need) : pad_last);

  always_comb begin
    case (st)
      S_DBUF:  mem_addr = cur_desc + ADDR_W'(4);
      S_DLEN:  mem_addr = cur_desc + ADDR_W'(8);
      S_DNXT:  mem_addr = cur_desc + ADDR_W'(12);
      S_FETCH: mem_addr = rd_ptr & WMASK;
      S_WLEN:  mem_addr = cur_desc + ADDR_W'(8);
      default: mem_addr = cur_desc;
    endcase
  end

  always_comb begin
    mem_wdata = '0;
    if (st == S_WFLG) begin
      mem_wdata = flags_q;
      mem_wdata[OWN_B] = 1'b0;
    end else begin
      mem_wdata[LEN_W-1:0] = len_q;
      mem_wdata[SENT_B] = !berr_q;
      mem_wdata[INTR_B] = intr_q && !berr_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      flags_q <= '0; word_q <= '0; next_q <= '0; rd_ptr <= '0;
      len_q <= '0; cnt <= '0; berr_q <= 1'b0; intr_q <= 1'b0; en_q <= 1'b0;
      cur_desc <= '0; cur_buf <= '0;
      ev_done <= 1'b0; ev_unavail <= 1'b0; ev_buserr <= 1'b0;
    end else begin
      en_q <= tx_en;
      ev_done <= 1'b0; ev_unavail <= 1'b0; ev_buserr <= 1'b0;
      if (tx_en && !en_q && !mem_req) cur_desc <= list_base & WMASK;
      if (abort) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_IDLE: if (poll && tx_en) st <= S_DFLG;
          S_DFLG: begin
            if (mem_err) begin
              ev_buserr <= 1'b1; st <= S_IDLE;
            end else if (mem_ack) begin
              flags_q <= mem_rdata;
              if (!mem_rdata[OWN_B]) begin
                ev_unavail <= 1'b1; st <= S_IDLE;
              end else st <= S_DBUF;
            end
          end
          S_DBUF: begin
            if (mem_err) begin
              ev_buserr <= 1'b1; st <= S_IDLE;
            end else if (mem_ack) begin
              cur_buf <= mem_rdata[ADDR_W-1:0];
              rd_ptr  <= mem_rdata[ADDR_W-1:0];
              st <= S_DLEN;
            end
          end
          S_DLEN: begin
            if (mem_err) begin
              ev_buserr <= 1'b1; st <= S_IDLE;
            end else if (mem_ack) begin
              len_q <= mem_rdata[LEN_W-1:0];
              st <= S_DNXT;
            end
          end
          S_DNXT: begin
            if (mem_err) begin
              ev_buserr <= 1'b1; st <= S_IDLE;
            end else if (mem_ack) begin
              next_q <= mem_rdata[ADDR_W-1:0];
              cnt <= '0;
              berr_q <= 1'b0;
              if (len_q != '0) st <= S_FETCH;
              else if (pad_need) st <= S_PAD;
              else begin
                ev_done <= flags_q[IE_B]; st <= S_WFLG;
              end
            end
          end
          S_FETCH: begin
            if (mem_err) begin
              ev_buserr <= 1'b1; berr_q <= 1'b1; st <= S_WFLG;
            end else if (mem_ack) begin
              word_q <= mem_rdata; st <= S_EMIT;
            end
          end
          S_EMIT: begin
            rd_ptr <= rd_ptr + ADDR_W'(1);
            cnt <= cnt + LEN_W'(1);
            if (buf_last) begin
              if (pad_need) st <= S_PAD;
              else begin
                ev_done <= flags_q[IE_B]; st <= S_WFLG;
              end
            end else if (rd_ptr[1:0] == 2'd3) st <= S_FETCH;
          end
          S_PAD: begin
            cnt <= cnt + LEN_W'(1);
            if (pad_last) begin
              ev_done <= flags_q[IE_B]; st <= S_WFLG;
            end
          end
          S_WFLG: if (beat_end) begin
            intr_q <= summary_irq; ev_buserr <= mem_err; st <= S_WLEN;
          end
          S_WLEN: if (beat_end) begin
            ev_buserr <= mem_err; cur_desc <= next_q & WMASK; st <= S_DFLG;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assert_hold_req_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !mem_err) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_load_ptr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_en) && !mem_req) |=> (cur_desc == ($past(list_base) & WMASK)));

  assert_stop_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !mem_req) |=> (!mem_req && !out_valid));

  assert_halt_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_unavail |-> (!mem_req && !out_valid));

  assert_last_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  assert_one_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_done, ev_unavail, ev_buserr}));

endmodule

// File: tb/test_txdesc_walker.sv
module test_txdesc_walker;
  logic clk = 1'b0, rst_n = 1'b0, tx_en = 1'b0, poll = 1'b0, summary_irq = 1'b0;
  logic [31:0] list_base = '0, mem_rdata = '0;
  logic mem_ack = 1'b0, mem_err = 1'b0;
  logic mem_req, mem_we, out_valid, out_last, ev_done, ev_unavail, ev_buserr;
  logic [31:0] mem_addr, mem_wdata, cur_desc, cur_buf;
  logic [7:0] out_data;

  txdesc_walker i_txdesc_walker (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .poll(poll), .list_base(list_base),
    .summary_irq(summary_irq), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .ev_done(ev_done),
    .ev_unavail(ev_unavail), .ev_buserr(ev_buserr), .cur_desc(cur_desc), .cur_buf(cur_buf));

  always #5 clk = ~clk;

  logic [31:0] mem [bit [31:0]];
  logic [31:0] exp_mem [bit [31:0]];
  logic [8:0]  exp_q [$];
  int checks = 0, fails = 0, cyc = 0, wcnt = 0, lat = 0;
  int n_done = 0, n_unav = 0, n_berr = 0, n_bytes = 0, n_req = 0, n_out = 0;
  int e_done = 0, e_unav = 0, e_berr = 0;
  logic [31:0] e_ptr = '0;

  function automatic bit bad(logic [31:0] a);
    return (a >= 32'hE000 && a < 32'hF000) || ((a & ~32'h3) == 32'h500);
  endfunction

  function automatic logic [31:0] rd(logic [31:0] a);
    logic [31:0] w = a & ~32'h3;
    return mem.exists(w) ? mem[w] : 32'h0;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      summary();
      $finish;
    end
  end

  always @(negedge clk) begin
    if (mem_ack || mem_err) begin
      mem_ack = 1'b0; mem_err = 1'b0; wcnt = 0;
    end else if (mem_req) begin
      if (wcnt >= lat) begin
        if (bad(mem_addr)) mem_err = 1'b1;
        else begin
          mem_ack = 1'b1;
          if (mem_we) mem[mem_addr] = mem_wdata;
          else mem_rdata = rd(mem_addr);
        end
        lat = (lat + 1) % 3;
      end else wcnt++;
    end
  end

  always @(posedge clk) begin
    #4;
    if (rst_n) begin
      if (mem_req) n_req++;
      if (ev_done) n_done++;
      if (ev_unavail) n_unav++;
      if (ev_buserr) n_berr++;
      if (out_valid) begin
        n_bytes++; n_out++;
        if (exp_q.size() == 0) chk(1'b0, "R5 unexpected byte", {23'b0, out_last, out_data}, 0);
        else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          chk({out_last, out_data} == e, "R5/R6 stream byte", {23'b0, out_last, out_data}, {23'b0, e});
        end
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_poll();
    poll = 1'b1; tick(1); poll = 1'b0;
  endtask

  task automatic fill(logic [31:0] a, int n);
    for (int i = 0; i < n; i++) begin
      logic [31:0] x = a + i;
      logic [31:0] w = x & ~32'h3;
      if (!mem.exists(w)) mem[w] = 32'h0;
      mem[w][8*x[1:0] +: 8] = x[7:0] ^ 8'h5A;
    end
  endtask

  task automatic predict(logic [31:0] start, bit sum);
    logic [31:0] p = start;
    e_done = 0; e_unav = 0; e_berr = 0;
    exp_mem.delete();
    for (int d = 0; d < 40; d++) begin
      logic [31:0] f, b, s, n, st;
      int len, tot;
      bit err;
      if (bad(p) || bad(p + 4) || bad(p + 8) || bad(p + 12)) begin e_berr++; break; end
      f = rd(p);
      if (!f[31]) begin e_unav++; break; end
      b = rd(p + 4); s = rd(p + 8); n = rd(p + 12);
      len = int'(s[15:0]);
      tot = (f[0] && len < 60) ? 60 : len;
      err = 1'b0;
      for (int i = 0; i < len; i++) begin
        logic [31:0] a = b + i;
        logic [31:0] w;
        if (bad(a)) begin err = 1'b1; break; end
        w = rd(a);
        exp_q.push_back({i == tot - 1, w[8*a[1:0] +: 8]});
      end
      if (!err) for (int i = len; i < tot; i++) exp_q.push_back({i == tot - 1, 8'h00});
      if (err) e_berr++; else if (f[2]) e_done++;
      exp_mem[p] = f & 32'h7FFF_FFFF;
      st = {14'b0, sum && !err, !err, s[15:0]};
      exp_mem[p + 8] = st;
      p = n & ~32'h3;
    end
    e_ptr = p;
  endtask

  task automatic run_and_compare(string tag);
    n_done = 0; n_unav = 0; n_berr = 0;
    pulse_poll();
    tick(600);
    chk(exp_q.size() == 0, {tag, " R3 all bytes sent"}, exp_q.size(), 0);
    chk(n_done == e_done, {tag, " R8 done events"}, n_done, e_done);
    chk(n_unav == e_unav, {tag, " R4 unavailable events"}, n_unav, e_unav);
    chk(n_berr == e_berr, {tag, " R10/R11 bus-error events"}, n_berr, e_berr);
    chk(cur_desc == e_ptr, {tag, " R7 descriptor pointer"}, cur_desc, e_ptr);
    foreach (exp_mem[k]) chk(rd(k) == exp_mem[k], {tag, " R7/R9 write-back"}, rd(k), exp_mem[k]);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk(!mem_req && !out_valid, "R1 idle after reset", {mem_req, out_valid}, 0);
    chk(cur_desc == 0 && cur_buf == 0, "R1 pointers after reset", cur_desc | cur_buf, 0);
    chk(!ev_done && !ev_unavail && !ev_buserr, "R1 events low", {ev_done, ev_unavail, ev_buserr}, 0);

    mem[32'h100] = 32'h8000_0004; mem[32'h104] = 32'h1001;
    mem[32'h108] = 32'h00FF_000A; mem[32'h10C] = 32'h202;
    mem[32'h200] = 32'h8000_0001; mem[32'h204] = 32'h2000;
    mem[32'h208] = 32'h0000_0005; mem[32'h20C] = 32'h300;
    mem[32'h300] = 32'h8000_0005; mem[32'h304] = 32'h2400;
    mem[32'h308] = 32'h0000_0000; mem[32'h30C] = 32'h380;
    mem[32'h380] = 32'h0000_0004; mem[32'h384] = 32'hE000;
    mem[32'h388] = 32'h0000_0008; mem[32'h38C] = 32'h400;
    mem[32'h400] = 32'h8000_0004; mem[32'h404] = 32'h4002;
    mem[32'h408] = 32'h0000_0003; mem[32'h40C] = 32'h500;
    mem[32'h600] = 32'h8000_0000; mem[32'h604] = 32'h3000;
    mem[32'h608] = 32'h0000_00C8; mem[32'h60C] = 32'h700;
    mem[32'h700] = 32'h0;
    fill(32'h1001, 10); fill(32'h2000, 5); fill(32'h4002, 3); fill(32'h3000, 200);

    list_base = 32'h103;
    pulse_poll();
    tick(10);
    chk(n_req == 0, "R3 poll ignored while disabled", n_req, 0);
    tx_en = 1'b1;
    tick(10);
    chk(n_req == 0, "R2 no fetch before poll", n_req, 0);
    chk(cur_desc == 32'h100, "R2 pointer loaded and aligned", cur_desc, 32'h100);

    summary_irq = 1'b1;
    predict(32'h100, 1'b1);
    run_and_compare("chain");
    chk(rd(32'h380) == 32'h4, "R4 owned-by-cpu descriptor untouched", rd(32'h380), 32'h4);
    chk(cur_buf == 32'h2400, "R12 buffer pointer", cur_buf, 32'h2400);

    summary_irq = 1'b0;
    mem[32'h380] = 32'h8000_0004;
    predict(32'h380, 1'b0);
    run_and_compare("errors");
    chk(cur_buf == 32'h4002, "R12 buffer pointer after errors", cur_buf, 32'h4002);
    chk(cur_desc == 32'h500, "R11 pointer held on descriptor error", cur_desc, 32'h500);

    tx_en = 1'b0; tick(2);
    list_base = 32'h600; tx_en = 1'b1; tick(2);
    predict(32'h600, 1'b0);
    n_bytes = 0; n_done = 0;
    pulse_poll();
    while (n_bytes < 20) tick(1);
    tx_en = 1'b0;
    tick(2);
    n_req = 0; n_out = 0;
    tick(30);
    chk(n_req == 0, "R13 no requests after stop", n_req, 0);
    chk(n_out == 0, "R13 no bytes after stop", n_out, 0);
    chk(rd(32'h600) == 32'h8000_0000, "R13 no write-back after stop", rd(32'h600), 32'h8000_0000);
    chk(n_done == 0, "R13 no done event after stop", n_done, 0);
    exp_q.delete();

    summary();
    $finish;
  end
endmodule